// File: doc/BRIEF.md
# Gate descriptor dispatch unit

This block carries out control transfers that pass through 64-bit gate descriptors held in memory. A software interrupt with vector n fetches its gate from the interrupt table at `int_base + 8*n`. A far call through a gate fetches from the gate table at `call_base + 8*n`. The unit decodes the gate, saves the caller's code selector and next-instruction pointer on the stack, and moves the current code pointer to the selector and 32-bit offset stored in the gate. For a call gate it first moves the number of 32-bit parameter words named in the gate from the caller's stack onto the privileged stack.

A return command takes the saved pointer and selector back off the stack. A gate of the task type is not executed here. It raises a one-cycle handoff strobe that carries the destination selector, for a separate task-switch unit. Privilege checks on the target segment belong to other logic. The unit keeps the current code selector, the code offset and the privileged stack pointer as registered outputs. It reaches memory through a single 32-bit word port with a read latency of one cycle.

Top module: `gate_dispatch`

## Requirements
- R1: After a synchronous reset, `cs_sel`, `cs_off` and `sp` hold the parameters RESET_SEL, RESET_OFF and RESET_SP, and `busy`, `done`, `fault`, `task_go`, `mem_re` and `mem_we` are all low.
- R2: `cmd_op` 1 (interrupt) reads its gate from `int_base + 8*cmd_index`, and `cmd_op` 2 (gate call) reads from `call_base + 8*cmd_index`. The word at that address is {selector[31:16], offset[15:0]}. The word 4 bytes above it is {offset[31:16], access[15:8], reserved[7:5], word_count[4:0]}.
- R3: A gate faults when any of these holds: access bit 7 (present) is 0, access bit 4 is 1, the reserved bits are nonzero, or access[3:0] is none of 0101, 0110, 1100. A faulting gate gives a one-cycle `fault` together with `done`, performs no memory write, and leaves `cs_sel`, `cs_off` and `sp` unchanged.
- R4: For type 0110 (interrupt gate) or 1100 (call gate), the unit writes the zero-extended `cs_sel` to `sp-4`, then writes `cmd_ret_off` to `sp-8`. It then loads `cs_sel` with the gate selector and `cs_off` with the full gate offset.
- R5: For type 1100 only, before the return pushes, the unit copies word_count words from the caller's stack to the privileged stack, starting with the word at `usr_sp + 4*(word_count-1)` and ending with the word at `usr_sp`. Word i lands at final `sp + 8 + 4*i`, and `sp` drops by `4*(word_count+2)`. A type-0110 gate ignores its word count.
- R6: For type 0101 (task gate), `task_go` pulses for one cycle with `task_sel` equal to the gate selector, together with `done`. No memory write takes place and `cs_sel`, `cs_off` and `sp` stay unchanged.
- R7: `cmd_op` 3 (return) loads `cs_off` from the word at `sp` and `cs_sel` from bits 15:0 of the word at `sp+4`, then adds 8 to `sp`.
- R8: A command is taken when `cmd_valid` is high and `busy` is low. `busy` stays high from the next cycle until the cycle in which `done` pulses. Commands that arrive while `busy` is high are ignored. Each accepted command gives exactly one `done`, and the unit never reads and writes memory in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | 1 interrupt, 2 gate call, 3 return, 0 no-op |
| cmd_index | input | IDX_W | Vector or gate index |
| cmd_ret_off | input | 32 | Next-instruction pointer to save |
| int_base | input | 32 | Interrupt gate table byte address |
| call_base | input | 32 | Call gate table byte address |
| usr_sp | input | 32 | Caller stack pointer, source of parameter words |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Read data, valid one cycle after `mem_re` |
| busy | output | 1 | Command in progress |
| done | output | 1 | Command completed (one cycle) |
| fault | output | 1 | Gate rejected (one cycle) |
| task_go | output | 1 | Task-gate handoff strobe (one cycle) |
| task_sel | output | 16 | Destination selector for the task handoff |
| cs_sel | output | 16 | Current code selector |
| cs_off | output | 32 | Current code offset |
| sp | output | 32 | Privileged stack pointer |

## Verification
The bench targets several corner cases. An interrupt gate with a nonzero word count must copy nothing; a design that keyed copying on the command instead of the gate type would shift the stack. Word counts of 0 and 31 are exercised, which exposes an off-by-one in the copy loop as a wrong `sp` or a misplaced parameter. Present-clear, S-set, reserved-bit and unknown-type gates must leave no trace in memory or in the code pointer; a unit that still pushed would show extra writes. A return must take the offset from the lower word and the selector from the upper word, and a command issued while busy must give no second `done`.

// File: rtl/gate_disp_pkg.sv
package gate_disp_pkg;

  localparam int WC_W = 5;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_INT  = 2'd1,
    OP_CALL = 2'd2,
    OP_RET  = 2'd3
  } op_e;

  localparam logic [3:0] TY_TASK = 4'b0101;
  localparam logic [3:0] TY_INTR = 4'b0110;
  localparam logic [3:0] TY_CALL = 4'b1100;

  typedef enum logic [1:0] {
    GK_BAD,
    GK_INTR,
    GK_CALL,
    GK_TASK
  } gkind_e;

  typedef struct packed {
    logic [15:0]     sel;
    logic [31:0]     off;
    logic [WC_W-1:0] wc;
    gkind_e          kind;
  } gate_t;

  typedef enum logic [3:0] {
    S_IDLE, S_GLO, S_GMID, S_GHI, S_DEC,
    S_CRD, S_CW1, S_CW2, S_PSEL, S_POFF,
    S_RW1, S_RC1, S_RC2
  } st_e;

endpackage

// File: rtl/gate_decode.sv
module gate_decode
  import gate_disp_pkg::*;
(
  input  logic [31:0] word_lo,
  input  logic [31:0] word_hi,
  output gate_t       gate
);
  logic [7:0] acc;

  always_comb begin
    acc       = word_hi[15:8];
    gate.sel  = word_lo[31:16];
    gate.off  = {word_hi[31:16], word_lo[15:0]};
    gate.wc   = word_hi[WC_W-1:0];
    gate.kind = GK_BAD;
    if (acc[7] && !acc[4] && (word_hi[7:5] == 3'b000)) begin
      unique case (acc[3:0])
        TY_INTR: gate.kind = GK_INTR;
        TY_CALL: gate.kind = GK_CALL;
        TY_TASK: gate.kind = GK_TASK;
        default: gate.kind = GK_BAD;
      endcase
    end
  end
endmodule

// File: rtl/gate_addr_unit.sv
module gate_addr_unit
  import gate_disp_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             use_call,
  input  logic [31:0]      int_base,
  input  logic [31:0]      call_base,
  input  logic [IDX_W-1:0] idx,
  input  logic [31:0]      usr_sp,
  input  logic [WC_W-1:0]  remain,
  output logic [31:0]      gate_addr,
  output logic [31:0]      copy_addr
);
  localparam int PADW = 32 - IDX_W - 3;
  localparam int CPAD = 32 - WC_W - 2;

  logic [31:0]     base;
  logic [WC_W-1:0] last;

  always_comb begin
    base      = use_call ? call_base : int_base;
    gate_addr = base + {{PADW{1'b0}}, idx, 3'b000};
    last      = remain - WC_W'(1);
    copy_addr = usr_sp + {{CPAD{1'b0}}, last, 2'b00};
  end
endmodule

// File: rtl/gate_dispatch.sv
module gate_dispatch
  import gate_disp_pkg::*;
#(
  parameter int          IDX_W     = 5,
  parameter logic [15:0] RESET_SEL = 16'h0008,
  parameter logic [31:0] RESET_OFF = 32'h0000_1000,
  parameter logic [31:0] RESET_SP  = 32'h0000_0F00
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [IDX_W-1:0] cmd_index,
  input  logic [31:0]      cmd_ret_off,
  input  logic [31:0]      int_base,
  input  logic [31:0]      call_base,
  input  logic [31:0]      usr_sp,
  output logic             mem_re,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic [31:0]      mem_rdata,
  output logic             busy,
  output logic             done,
  output logic             fault,
  output logic             task_go,
  output logic [15:0]      task_sel,
  output logic [15:0]      cs_sel,
  output logic [31:0]      cs_off,
  output logic [31:0]      sp
);
  st_e             st;
  logic [31:0]     gaddr_q, lo_q, hi_q, ret_q, tmp_off;
  logic [WC_W-1:0] cnt;
  logic [31:0]     gate_addr, copy_addr;
  gate_t           g;
  logic            accept;

  assign accept = cmd_valid && (cmd_op != OP_NONE);

  gate_addr_unit #(.IDX_W(IDX_W)) u_addr (
    .use_call (cmd_op == OP_CALL),
    .int_base (int_base),
    .call_base(call_base),
    .idx      (cmd_index),
    .usr_sp   (usr_sp),
    .remain   (cnt),
    .gate_addr(gate_addr),
    .copy_addr(copy_addr)
  );

  gate_decode u_dec (
    .word_lo(lo_q),
    .word_hi(hi_q),
    .gate   (g)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      busy      <= 1'b0;
      done      <= 1'b0;
      fault     <= 1'b0;
      task_go   <= 1'b0;
      task_sel  <= '0;
      cs_sel    <= RESET_SEL;
      cs_off    <= RESET_OFF;
      sp        <= RESET_SP;
      mem_re    <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      gaddr_q   <= '0;
      lo_q      <= '0;
      hi_q      <= '0;
      ret_q     <= '0;
      tmp_off   <= '0;
      cnt       <= '0;
    end else begin
      done    <= 1'b0;
      fault   <= 1'b0;
      task_go <= 1'b0;
      mem_re  <= 1'b0;
      mem_we  <= 1'b0;
      unique case (st)
        S_IDLE: if (accept) begin
          busy   <= 1'b1;
          ret_q  <= cmd_ret_off;
          mem_re <= 1'b1;
          if (cmd_op == OP_RET) begin
            mem_addr <= sp;
            st       <= S_RW1;
          end else begin
            mem_addr <= gate_addr;
            gaddr_q  <= gate_addr;
            st       <= S_GLO;
          end
        end
        S_GLO: begin
          mem_re   <= 1'b1;
          mem_addr <= gaddr_q + 32'd4;
          st       <= S_GMID;
        end
        S_GMID: begin
          lo_q <= mem_rdata;
          st   <= S_GHI;
        end
        S_GHI: begin
          hi_q <= mem_rdata;
          st   <= S_DEC;
        end
        S_DEC: begin
          unique case (g.kind)
            GK_BAD: begin
              fault <= 1'b1;
              done  <= 1'b1;
              busy  <= 1'b0;
              st    <= S_IDLE;
            end
            GK_TASK: begin
              task_go  <= 1'b1;
              task_sel <= g.sel;
              done     <= 1'b1;
              busy     <= 1'b0;
              st       <= S_IDLE;
            end
            GK_CALL: begin
              cnt <= g.wc;
              st  <= (g.wc != '0) ? S_CRD : S_PSEL;
            end
            default: st <= S_PSEL;
          endcase
        end
        S_CRD: begin
          mem_re   <= 1'b1;
          mem_addr <= copy_addr;
          st       <= S_CW1;
        end
        S_CW1: st <= S_CW2;
        S_CW2: begin
          mem_we    <= 1'b1;
          mem_addr  <= sp - 32'd4;
          mem_wdata <= mem_rdata;
          sp        <= sp - 32'd4;
          cnt       <= cnt - WC_W'(1);
          st        <= (cnt == WC_W'(1)) ? S_PSEL : S_CRD;
        end
        S_PSEL: begin
          mem_we    <= 1'b1;
          mem_addr  <= sp - 32'd4;
          mem_wdata <= {16'h0000, cs_sel};
          sp        <= sp - 32'd4;
          st        <= S_POFF;
        end
        S_POFF: begin
          mem_we    <= 1'b1;
          mem_addr  <= sp - 32'd4;
          mem_wdata <= ret_q;
          sp        <= sp - 32'd4;
          cs_sel    <= g.sel;
          cs_off    <= g.off;
          done      <= 1'b1;
          busy      <= 1'b0;
          st        <= S_IDLE;
        end
        S_RW1: begin
          mem_re   <= 1'b1;
          mem_addr <= sp + 32'd4;
          st       <= S_RC1;
        end
        S_RC1: begin
          tmp_off <= mem_rdata;
          st      <= S_RC2;
        end
        S_RC2: begin
          cs_off <= tmp_off;
          cs_sel <= mem_rdata[15:0];
          sp     <= sp + 32'd8;
          done   <= 1'b1;
          busy   <= 1'b0;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R8: memory port is never read and written together
  p_rw_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(mem_re && mem_we));

  // R8: completion is a single-cycle pulse and ends the busy window
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R3: a rejected gate leaves the code pointer and stack alone
  p_fault_hold_r3: assert property (@(posedge clk) disable iff (rst)
    fault |-> ($stable(cs_sel) && $stable(cs_off) && $stable(sp)));

  // R6: a task handoff does not touch stack or code pointer
  p_task_hold_r6: assert property (@(posedge clk) disable iff (rst)
    task_go |-> ($stable(sp) && $stable(cs_sel) && $stable(cs_off)));

  // R4: every stack write goes to the slot the pointer now names
  p_push_addr_r4: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_addr == sp));

  // R7: completing a return raises the stack pointer by two words
  p_ret_sp_r7: assert property (@(posedge clk) disable iff (rst)
    $past(st == S_RC2) |-> (sp == $past(sp) + 32'd8));

endmodule

// File: tb/test_gate_dispatch.sv
`timescale 1ns/1ps
module test_gate_dispatch;
  localparam int          IDX_W = 5;
  localparam logic [15:0] R_SEL = 16'h0008;
  localparam logic [31:0] R_OFF = 32'h0000_1000;
  localparam logic [31:0] R_SP  = 32'h0000_0F00;
  localparam logic [31:0] IB    = 32'h0000_0100;
  localparam logic [31:0] CB    = 32'h0000_0300;
  localparam logic [31:0] USP   = 32'h0000_0600;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic             rst = 1'b1;
  logic             cmd_valid = 1'b0;
  logic [1:0]       cmd_op = 2'd0;
  logic [IDX_W-1:0] cmd_index = '0;
  logic [31:0]      cmd_ret_off = '0;
  logic             mem_re, mem_we, busy, done, fault, task_go;
  logic [31:0]      mem_addr, mem_wdata, cs_off, sp;
  logic [31:0]      mem_rdata = '0;
  logic [15:0]      task_sel, cs_sel;

  gate_dispatch #(.IDX_W(IDX_W), .RESET_SEL(R_SEL), .RESET_OFF(R_OFF), .RESET_SP(R_SP)) i_gate_dispatch (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_index(cmd_index),
    .cmd_ret_off(cmd_ret_off), .int_base(IB), .call_base(CB), .usr_sp(USP),
    .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .busy(busy), .done(done), .fault(fault), .task_go(task_go),
    .task_sel(task_sel), .cs_sel(cs_sel), .cs_off(cs_off), .sp(sp)
  );

  logic [31:0] ram     [0:1023];
  logic [31:0] exp_mem [0:1023];
  logic        tb_we = 1'b0;
  logic [31:0] tb_addr = '0, tb_data = '0;
  int          wr_cnt = 0;

  always @(posedge clk) begin
    if (mem_we) begin
      ram[mem_addr[11:2]] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
    end else if (tb_we) ram[tb_addr[11:2]] <= tb_data;
    if (mem_re) mem_rdata <= ram[mem_addr[11:2]];
  end

  int nchk = 0, nerr = 0;
  logic [15:0] e_sel;
  logic [31:0] e_off, e_sp;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic put_word(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    tb_we = 1'b1; tb_addr = a; tb_data = d;
    exp_mem[a[11:2]] = d;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic set_gate(input logic [31:0] base, input int idx, input logic [15:0] s,
                          input logic [31:0] o, input logic [7:0] acc,
                          input logic [2:0] rsv, input logic [4:0] wc);
    put_word(base + 32'(idx * 8), {s, o[15:0]});
    put_word(base + 32'(idx * 8) + 32'd4, {o[31:16], acc, rsv, wc});
  endtask

  task automatic run_op(input logic [1:0] op, input int idx, input logic [31:0] ret, input bit poke);
    logic [31:0] a, lo, hi;
    logic [7:0]  acc;
    int          wc, e_wr, w0, t, extra, bad;
    string       tag;
    logic        e_fault, e_task, g_fault, g_task;
    logic [15:0] e_tsel, g_tsel, g_sel;
    logic [31:0] g_off, g_sp;
    e_fault = 1'b0; e_task = 1'b0; e_tsel = '0; e_wr = 0;
    if (op == 2'd3) begin
      tag   = "R7";
      e_off = exp_mem[e_sp[11:2]];
      e_sel = exp_mem[10'(e_sp[11:2] + 10'd1)][15:0];
      e_sp  = e_sp + 32'd8;
    end else begin
      a   = ((op == 2'd1) ? IB : CB) + 32'(idx * 8);
      lo  = exp_mem[a[11:2]];
      hi  = exp_mem[10'(a[11:2] + 10'd1)];
      acc = hi[15:8];
      wc  = int'(hi[4:0]);
      if (!acc[7] || acc[4] || hi[7:5] != 3'b000 ||
          !(acc[3:0] inside {4'b0101, 4'b0110, 4'b1100})) begin
        tag = "R3"; e_fault = 1'b1;
      end else if (acc[3:0] == 4'b0101) begin
        tag = "R6"; e_task = 1'b1; e_tsel = lo[31:16];
      end else begin
        if (acc[3:0] == 4'b1100 && wc > 0) begin
          tag = "R5";
          for (int i = wc - 1; i >= 0; i--) begin
            e_sp = e_sp - 32'd4;
            exp_mem[e_sp[11:2]] = exp_mem[10'(int'(USP[11:2]) + i)];
            e_wr++;
          end
        end else tag = "R4";
        e_sp = e_sp - 32'd4; exp_mem[e_sp[11:2]] = {16'h0000, e_sel};
        e_sp = e_sp - 32'd4; exp_mem[e_sp[11:2]] = ret;
        e_wr += 2;
        e_sel = lo[31:16];
        e_off = {hi[31:16], lo[15:0]};
      end
    end
    w0 = wr_cnt;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_index = idx[IDX_W-1:0]; cmd_ret_off = ret;
    @(negedge clk);
    if (poke) begin
      chk(busy == 1'b1, "R8", "busy after accept", 32'(busy), 32'd1);
      cmd_op = 2'd3;
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    t = 0;
    while (!done && t < 400) begin @(negedge clk); t++; end
    chk(t < 400, "R8", "completion timeout", 32'(t), 32'd0);
    g_fault = fault; g_task = task_go; g_tsel = task_sel;
    g_sel = cs_sel; g_off = cs_off; g_sp = sp;
    extra = 0;
    repeat (8) begin @(negedge clk); if (done) extra++; end
    chk(extra == 0, "R8", "extra done pulses", 32'(extra), 32'd0);
    chk(g_sel === e_sel, tag, "code selector (R2)", 32'(g_sel), 32'(e_sel));
    chk(g_off === e_off, tag, "code offset (R2)", g_off, e_off);
    chk(g_sp === e_sp, tag, "stack pointer", g_sp, e_sp);
    chk(g_fault === e_fault, tag, "fault flag", 32'(g_fault), 32'(e_fault));
    chk(g_task === e_task, tag, "task strobe", 32'(g_task), 32'(e_task));
    if (e_task) chk(g_tsel === e_tsel, tag, "task selector", 32'(g_tsel), 32'(e_tsel));
    chk(wr_cnt - w0 == e_wr, tag, "memory write count", 32'(wr_cnt - w0), 32'(e_wr));
    bad = 0;
    for (int k = 0; k < 1024; k++) if (ram[k] !== exp_mem[k]) bad++;
    chk(bad == 0, tag, "memory image mismatches", 32'(bad), 32'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL R8 watchdog: got %0d expected %0d", 190000, 0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    int seed, r;
    logic [1:0] op;
    seed = int'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(cs_sel == R_SEL, "R1", "cs_sel", 32'(cs_sel), 32'(R_SEL));
    chk(cs_off == R_OFF, "R1", "cs_off", cs_off, R_OFF);
    chk(sp == R_SP, "R1", "sp", sp, R_SP);
    chk({busy, done, fault, task_go, mem_re, mem_we} == 6'b0, "R1", "control outputs",
        32'({busy, done, fault, task_go, mem_re, mem_we}), 32'd0);
    e_sel = R_SEL; e_off = R_OFF; e_sp = R_SP;

    for (int k = 0; k < 1024; k++) put_word(32'(k * 4), 32'd0);
    for (int k = 0; k < 32; k++) put_word(USP + 32'(k * 4), $urandom);

    // directed gates
    set_gate(IB, 2,  16'h0010, 32'h1234_5678, 8'h86, 3'b000, 5'd5);  // R5 count ignored
    set_gate(CB, 1,  16'h0020, 32'hCAFE_0040, 8'h8C, 3'b000, 5'd3);
    set_gate(CB, 3,  16'h0028, 32'h0000_2000, 8'hEC, 3'b000, 5'd0);
    set_gate(CB, 4,  16'h0030, 32'h8000_0004, 8'h8C, 3'b000, 5'd31);
    set_gate(CB, 5,  16'h0058, 32'h0BAD_0BAD, 8'h85, 3'b000, 5'd0);
    set_gate(IB, 6,  16'h0040, 32'h1111_1111, 8'h06, 3'b000, 5'd0);  // P clear
    set_gate(IB, 7,  16'h0040, 32'h2222_2222, 8'h96, 3'b000, 5'd0);  // S set
    set_gate(IB, 8,  16'h0040, 32'h3333_3333, 8'h8E, 3'b000, 5'd0);  // unknown type
    set_gate(IB, 9,  16'h0040, 32'h4444_4444, 8'h86, 3'b101, 5'd0);  // reserved bits
    set_gate(IB, 10, 16'h0048, 32'h5555_0010, 8'h8C, 3'b000, 5'd2);
    set_gate(IB, 31, 16'h0050, 32'hFFFF_FFF0, 8'hE6, 3'b000, 5'd0);  // R2 top index

    run_op(2'd1, 2,  32'h0000_1004, 1'b0);  // R4
    run_op(2'd2, 1,  32'h0000_1010, 1'b1);  // R5 + R8 poke
    run_op(2'd2, 3,  32'h0000_1020, 1'b0);  // R4 zero count
    run_op(2'd3, 0,  32'h0, 1'b0);          // R7
    run_op(2'd3, 0,  32'h0, 1'b0);
    run_op(2'd2, 4,  32'h0000_1030, 1'b0);  // R5 max count
    run_op(2'd3, 0,  32'h0, 1'b0);
    run_op(2'd2, 5,  32'h0000_1040, 1'b0);  // R6
    run_op(2'd1, 6,  32'h0000_1050, 1'b0);  // R3
    run_op(2'd1, 7,  32'h0000_1054, 1'b0);  // R3
    run_op(2'd1, 8,  32'h0000_1058, 1'b0);  // R3
    run_op(2'd1, 9,  32'h0000_105C, 1'b0);  // R3
    run_op(2'd1, 10, 32'h0000_1060, 1'b0);  // R5 via interrupt command
    run_op(2'd1, 31, 32'h0000_1064, 1'b0);  // R2

    // random tables
    for (int t = 0; t < 2; t++) begin
      for (int k = 0; k < 32; k++) begin
        logic [7:0] acc;
        logic [2:0] rsv;
        r = int'($urandom % 8);
        rsv = 3'b000;
        case (r)
          0, 1, 2: acc = {1'b1, 2'($urandom), 1'b0, 4'b0110};
          3, 4:    acc = {1'b1, 2'($urandom), 1'b0, 4'b1100};
          5:       acc = {1'b1, 2'($urandom), 1'b0, 4'b0101};
          6:       acc = 8'h80 | 8'($urandom % 16) | 8'h01;
          default: begin acc = 8'h86; rsv = 3'($urandom % 7 + 1); end
        endcase
        set_gate(t == 0 ? IB : CB, k, 16'($urandom), $urandom, acc, rsv, 5'($urandom % 8));
      end
    end

    for (int n = 0; n < 300; n++) begin
      r = int'($urandom % 8);
      if (e_sp < R_SP && (e_sp < 32'h0000_0A00 || r < 2)) op = 2'd3;
      else op = (r % 2 == 0) ? 2'd1 : 2'd2;
      run_op(op, int'($urandom % 32), $urandom, ($urandom % 16) == 0 && op != 2'd3);
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule